// File: doc/BRIEF.md
# SPI NOR flash command responder

This block stands in for the command side of a serial NOR flash device. It sits behind an external serial shifter that turns the serial lines into whole bytes. Each received byte arrives on `mosi_byte_i` together with a one-cycle `byte_vld_i` strobe. The block answers with `miso_byte_o`, which is the byte the shifter must send out during the next byte slot of the same frame. The frame is delimited by the active-low select `csn_i`.

The block holds an 8-bit status register and three identity constants: a manufacturer code, a memory type and a device code. Seven commands are decoded:

- write-enable and write-disable;
- status read and status write;
- a three-byte identity read;
- a wake-up command that returns the device code after dummy bytes;
- a manufacturer/device read whose reply order is chosen by a selector byte.

Bytes are numbered from 1 within a frame, and byte 1 is the opcode. After the strobe of byte k, `miso_byte_o` holds the reply for byte k+1. It holds 0xFF whenever no reply is defined.

Top module: `spi_nor_responder`

## Requirements
- R1: After reset the status register reads 0x00, and `miso_byte_o` is 0xFF.
- R2: The status byte layout is: bit 7 status-write lock, bit 6 continuous-program flag, bits 5:2 protect field, bit 1 write-enable latch, bit 0 busy flag. The busy flag always reads 0. A status write never alters bits 1:0 from its data byte.
- R3: Opcode 0x06 sets the write-enable latch as soon as the opcode byte is strobed. Opcode 0x04 clears it in the same way.
- R4: Opcode 0x05 returns the current status byte for byte 2 and for every further byte while `csn_i` stays low.
- R5: Opcode 0x01 followed by one or two data bytes loads bits 7:2 of the first data byte into status bits 7:2 when `csn_i` next goes high, and clears the write-enable latch. A second data byte has no effect.
- R6: A status write frame with no data byte, or with three or more data bytes, leaves the status register unchanged.
- R7: A status write is ignored, and the write-enable latch is kept, when the latch is clear or when status bit 7 is set.
- R8: Opcode 0x9F returns the manufacturer code, the memory type and the device code on bytes 2, 3 and 4, then 0xFF.
- R9: Opcode 0xAB returns 0xFF on bytes 2 to 4 (dummy bytes) and the device code on byte 5, then 0xFF.
- R10: Opcode 0x90 takes its selector in byte 4. Selector 0x00 gives the manufacturer code on byte 5 and the device code on byte 6. Any other selector gives the device code first. Later bytes return 0xFF.
- R11: An unknown opcode makes every following reply 0xFF until deselect. `miso_byte_o` is 0xFF whenever `csn_i` is high, and strobes while `csn_i` is high are ignored.
- R12: Raising `csn_i` part way through any command ends it. The next byte after reselect is decoded as a new opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csn_i | input | 1 | Active-low frame select |
| byte_vld_i | input | 1 | One-cycle strobe for a received byte |
| mosi_byte_i | input | 8 | Received byte |
| miso_byte_o | output | 8 | Reply byte for the next byte slot |

## Verification
A corrupted status register cannot be seen directly at the ports. It becomes visible only on the next status read frame, and only one reply byte after that frame's opcode is strobed. For this reason every status-changing scenario is followed at once by a read frame.

A wrong byte position or wrong latched opcode shows on `miso_byte_o` one cycle after the strobe concerned. The bench therefore samples every reply byte of the identity commands.

Missing deselect handling shows in two ways: a write that lands too early or never, or a frame whose next opcode is misread.

// File: rtl/spi_nor_pkg.sv
package spi_nor_pkg;

    localparam logic [7:0] OP_WR_EN    = 8'h06;
    localparam logic [7:0] OP_WR_DIS   = 8'h04;
    localparam logic [7:0] OP_RD_STAT  = 8'h05;
    localparam logic [7:0] OP_WR_STAT  = 8'h01;
    localparam logic [7:0] OP_RD_IDENT = 8'h9F;
    localparam logic [7:0] OP_WAKE_ID  = 8'hAB;
    localparam logic [7:0] OP_MFR_DEV  = 8'h90;

    localparam logic [7:0] IDLE_BYTE   = 8'hFF;

    typedef enum logic [3:0] {
        CMD_IDLE,
        CMD_WR_EN,
        CMD_WR_DIS,
        CMD_RD_STAT,
        CMD_WR_STAT,
        CMD_RD_IDENT,
        CMD_WAKE_ID,
        CMD_MFR_DEV,
        CMD_UNKNOWN
    } cmd_e;

    typedef struct packed {
        logic       wr_lock;
        logic       cont_prog;
        logic [3:0] protect;
        logic       wr_enable;
        logic       busy;
    } status_t;

    function automatic cmd_e opcode_to_cmd(input logic [7:0] op);
        cmd_e c;
        case (op)
            OP_WR_EN:    c = CMD_WR_EN;
            OP_WR_DIS:   c = CMD_WR_DIS;
            OP_RD_STAT:  c = CMD_RD_STAT;
            OP_WR_STAT:  c = CMD_WR_STAT;
            OP_RD_IDENT: c = CMD_RD_IDENT;
            OP_WAKE_ID:  c = CMD_WAKE_ID;
            OP_MFR_DEV:  c = CMD_MFR_DEV;
            default:     c = CMD_UNKNOWN;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/spi_nor_opcode_decode.sv
module spi_nor_opcode_decode
    import spi_nor_pkg::*;
(
    input  logic [7:0] op_i,
    output cmd_e       cmd_o
);
    always_comb cmd_o = opcode_to_cmd(op_i);
endmodule

// File: rtl/spi_nor_frame_track.sv
module spi_nor_frame_track
    import spi_nor_pkg::*;
#(
    parameter int POS_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             csn_i,
    input  logic             byte_vld_i,
    input  logic [7:0]       mosi_byte_i,
    input  cmd_e             cmd_dec_i,
    output cmd_e             cmd_q_o,
    output cmd_e             cmd_now_o,
    output logic [POS_W-1:0] pos_next_o,
    output logic             sel_mfr_first_o,
    output logic [5:0]       wr_bits_o,
    output logic             commit_o
);
    localparam logic [POS_W-1:0] POS_MAX    = {POS_W{1'b1}};
    localparam logic [POS_W-1:0] POS_SELECT = POS_W'(3);
    localparam int               WCNT_W     = 2;
    localparam logic [WCNT_W-1:0] WCNT_MAX  = {WCNT_W{1'b1}};

    logic [POS_W-1:0]  pos_q;
    cmd_e              cmd_q;
    logic [WCNT_W-1:0] wcnt_q;
    logic [5:0]        wr_bits_q;
    logic              sel_q;

    assign pos_next_o = (pos_q == POS_MAX) ? pos_q : pos_q + POS_W'(1);

    assign cmd_now_o = (pos_q == '0) ? cmd_dec_i : cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q     <= '0;
            cmd_q     <= CMD_IDLE;
            wcnt_q    <= '0;
            wr_bits_q <= '0;
            sel_q     <= 1'b0;
        end else if (csn_i) begin
            pos_q  <= '0;
            cmd_q  <= CMD_IDLE;
            wcnt_q <= '0;
        end else if (byte_vld_i) begin
            pos_q <= pos_next_o;
            if (pos_q == '0) begin
                cmd_q <= cmd_dec_i;
            end
            if (cmd_q == CMD_WR_STAT && pos_q != '0) begin
                if (wcnt_q == '0) begin
                    wr_bits_q <= mosi_byte_i[7:2];
                end
                if (wcnt_q != WCNT_MAX) begin
                    wcnt_q <= wcnt_q + WCNT_W'(1);
                end
            end
            if (cmd_q == CMD_MFR_DEV && pos_q == POS_SELECT) begin
                sel_q <= (mosi_byte_i == 8'h00);
            end
        end
    end

    assign cmd_q_o         = cmd_q;
    assign sel_mfr_first_o = sel_q;
    assign wr_bits_o       = wr_bits_q;
    assign commit_o        = csn_i && (cmd_q == CMD_WR_STAT) &&
                             (wcnt_q == WCNT_W'(1) || wcnt_q == WCNT_W'(2));
endmodule

// File: rtl/spi_nor_status_reg.sv
module spi_nor_status_reg
    import spi_nor_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       set_wel_i,
    input  logic       clr_wel_i,
    input  logic       commit_i,
    input  logic [5:0] wr_bits_i,
    output status_t    stat_o
);
    status_t stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q.busy <= 1'b0;
            if (set_wel_i) begin
                stat_q.wr_enable <= 1'b1;
            end else if (clr_wel_i) begin
                stat_q.wr_enable <= 1'b0;
            end else if (commit_i && stat_q.wr_enable && !stat_q.wr_lock) begin
                stat_q.wr_lock   <= wr_bits_i[5];
                stat_q.cont_prog <= wr_bits_i[4];
                stat_q.protect   <= wr_bits_i[3:0];
                stat_q.wr_enable <= 1'b0;
            end
        end
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/spi_nor_reply_sel.sv
module spi_nor_reply_sel
    import spi_nor_pkg::*;
#(
    parameter int         POS_W    = 4,
    parameter logic [7:0] MFR_CODE = 8'hC2,
    parameter logic [7:0] MEM_TYPE = 8'h20,
    parameter logic [7:0] DEV_CODE = 8'h15
) (
    input  cmd_e             cmd_i,
    input  logic [POS_W-1:0] pos_next_i,
    input  logic [7:0]       mosi_byte_i,
    input  logic             sel_mfr_first_i,
    input  status_t          stat_i,
    output logic [7:0]       reply_o
);
    localparam logic [POS_W-1:0] P2 = POS_W'(1);
    localparam logic [POS_W-1:0] P3 = POS_W'(2);
    localparam logic [POS_W-1:0] P4 = POS_W'(3);
    localparam logic [POS_W-1:0] P5 = POS_W'(4);
    localparam logic [POS_W-1:0] P6 = POS_W'(5);

    always_comb begin
        reply_o = IDLE_BYTE;
        case (cmd_i)
            CMD_RD_STAT: reply_o = stat_i;
            CMD_RD_IDENT: begin
                if (pos_next_i == P2)      reply_o = MFR_CODE;
                else if (pos_next_i == P3) reply_o = MEM_TYPE;
                else if (pos_next_i == P4) reply_o = DEV_CODE;
            end
            CMD_WAKE_ID: begin
                if (pos_next_i == P5) reply_o = DEV_CODE;
            end
            CMD_MFR_DEV: begin
                if (pos_next_i == P5)
                    reply_o = (mosi_byte_i == 8'h00) ? MFR_CODE : DEV_CODE;
                else if (pos_next_i == P6)
                    reply_o = sel_mfr_first_i ? DEV_CODE : MFR_CODE;
            end
            default: reply_o = IDLE_BYTE;
        endcase
    end
endmodule

// File: rtl/spi_nor_responder.sv
module spi_nor_responder
    import spi_nor_pkg::*;
#(
    parameter int         POS_W    = 4,
    parameter logic [7:0] MFR_CODE = 8'hC2,
    parameter logic [7:0] MEM_TYPE = 8'h20,
    parameter logic [7:0] DEV_CODE = 8'h15
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       csn_i,
    input  logic       byte_vld_i,
    input  logic [7:0] mosi_byte_i,
    output logic [7:0] miso_byte_o
);
    cmd_e             cmd_dec;
    cmd_e             cmd_q;
    cmd_e             cmd_now;
    logic [POS_W-1:0] pos_next;
    logic             sel_mfr_first;
    logic [5:0]       wr_bits;
    logic             commit;
    status_t          stat;
    logic [7:0]       status_bits;
    logic [7:0]       reply;
    logic [7:0]       miso_q;
    logic             opcode_stb;

    spi_nor_opcode_decode u_dec (
        .op_i  (mosi_byte_i),
        .cmd_o (cmd_dec)
    );

    spi_nor_frame_track #(.POS_W(POS_W)) u_frame (
        .clk             (clk),
        .rst             (rst),
        .csn_i           (csn_i),
        .byte_vld_i      (byte_vld_i),
        .mosi_byte_i     (mosi_byte_i),
        .cmd_dec_i       (cmd_dec),
        .cmd_q_o         (cmd_q),
        .cmd_now_o       (cmd_now),
        .pos_next_o      (pos_next),
        .sel_mfr_first_o (sel_mfr_first),
        .wr_bits_o       (wr_bits),
        .commit_o        (commit)
    );

    assign opcode_stb = !csn_i && byte_vld_i && (cmd_q == CMD_IDLE);

    spi_nor_status_reg u_stat (
        .clk       (clk),
        .rst       (rst),
        .set_wel_i (opcode_stb && cmd_dec == CMD_WR_EN),
        .clr_wel_i (opcode_stb && cmd_dec == CMD_WR_DIS),
        .commit_i  (commit),
        .wr_bits_i (wr_bits),
        .stat_o    (stat)
    );

    assign status_bits = stat;

    spi_nor_reply_sel #(
        .POS_W    (POS_W),
        .MFR_CODE (MFR_CODE),
        .MEM_TYPE (MEM_TYPE),
        .DEV_CODE (DEV_CODE)
    ) u_reply (
        .cmd_i           (cmd_now),
        .pos_next_i      (pos_next),
        .mosi_byte_i     (mosi_byte_i),
        .sel_mfr_first_i (sel_mfr_first),
        .stat_i          (stat),
        .reply_o         (reply)
    );

    always_ff @(posedge clk) begin
        if (rst || csn_i) begin
            miso_q <= IDLE_BYTE;
        end else if (byte_vld_i) begin
            miso_q <= reply;
        end
    end

    assign miso_byte_o = miso_q;
endmodule

// File: rtl/spi_nor_responder_chk.sv
module spi_nor_responder_chk
    import spi_nor_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       csn_i,
    input logic       byte_vld_i,
    input logic [7:0] miso_byte_o,
    input logic [7:0] stat,
    input cmd_e       cmd_q
);
    p_idle_ff_r11: assert property (@(posedge clk) disable iff (rst)
        csn_i |=> miso_byte_o == 8'hFF);

    p_busy_zero_r2: assert property (@(posedge clk) disable iff (rst)
        stat[0] == 1'b0);

    p_write_needs_wel_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(stat[7:2]) |-> ($past(stat[1]) && !$past(stat[7])));

    p_write_at_deselect_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(stat[7:2]) |-> $past(csn_i));

    p_wel_set_on_byte_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(stat[1]) |-> ($past(byte_vld_i) && !$past(csn_i)));

    p_unknown_ff_r11: assert property (@(posedge clk) disable iff (rst)
        (!csn_i && cmd_q == CMD_UNKNOWN) |-> miso_byte_o == 8'hFF);
endmodule

bind spi_nor_responder spi_nor_responder_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .csn_i       (csn_i),
    .byte_vld_i  (byte_vld_i),
    .miso_byte_o (miso_byte_o),
    .stat        (status_bits),
    .cmd_q       (cmd_q)
);

// File: tb/spi_nor_responder_tb_top.sv
module spi_nor_responder_tb_top;

    localparam logic [7:0] MFR = 8'hC2;
    localparam logic [7:0] TYP = 8'h20;
    localparam logic [7:0] DEV = 8'h15;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       csn = 1'b1;
    logic       vld = 1'b0;
    logic [7:0] mosi = 8'h00;
    logic [7:0] miso;
    int         n_chk = 0;
    int         n_bad = 0;

    always #5 clk = ~clk;

    spi_nor_responder dut_i (
        .clk         (clk),
        .rst         (rst),
        .csn_i       (csn),
        .byte_vld_i  (vld),
        .mosi_byte_i (mosi),
        .miso_byte_o (miso)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, output logic [7:0] r);
        @(negedge clk);
        csn  = 1'b0;
        vld  = 1'b1;
        mosi = b;
        @(negedge clk);
        vld  = 1'b0;
        r    = miso;
    endtask

    task automatic deselect();
        @(negedge clk);
        csn = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic read_status(input string req, input logic [7:0] exp);
        logic [7:0] r;
        send(8'h05, r);
        check(req, r, exp);
        deselect();
    endtask

    task automatic t_reset();
        check("R1 reset miso", miso, 8'hFF);
        read_status("R1 reset status", 8'h00);
    endtask

    task automatic t_wel();
        logic [7:0] r;
        send(8'h06, r);
        deselect();
        read_status("R3 write-enable sets latch", 8'h02);
        send(8'h04, r);
        deselect();
        read_status("R3 write-disable clears latch", 8'h00);
    endtask

    task automatic t_rdsr_repeat();
        logic [7:0] r;
        send(8'h06, r);
        deselect();
        send(8'h05, r);
        check("R4 status byte 2", r, 8'h02);
        for (int i = 0; i < 3; i++) begin
            send(8'h00, r);
            check("R4 status repeated", r, 8'h02);
        end
        deselect();
        send(8'h04, r);
        deselect();
    endtask

    task automatic t_wrsr();
        logic [7:0] r;
        send(8'h06, r);
        deselect();
        send(8'h01, r);
        send(8'h7F, r);
        deselect();
        read_status("R5 one-byte write, low bits kept (R2)", 8'h7C);
        send(8'h06, r);
        deselect();
        send(8'h01, r);
        send(8'h3C, r);
        send(8'hAA, r);
        deselect();
        read_status("R5 two-byte write, second ignored", 8'h3C);
    endtask

    task automatic t_wrsr_rejects();
        logic [7:0] r;
        send(8'h01, r);
        send(8'h00, r);
        deselect();
        read_status("R7 write without latch ignored", 8'h3C);
        send(8'h06, r);
        deselect();
        send(8'h01, r);
        for (int i = 0; i < 3; i++) send(8'h00, r);
        deselect();
        read_status("R6 three data bytes ignored", 8'h3E);
        send(8'h01, r);
        deselect();
        read_status("R6 no data byte ignored", 8'h3E);
        send(8'h04, r);
        deselect();
    endtask

    task automatic t_ident();
        logic [7:0] r;
        send(8'h9F, r);
        check("R8 ident byte 2", r, MFR);
        send(8'h00, r);
        check("R8 ident byte 3", r, TYP);
        send(8'h00, r);
        check("R8 ident byte 4", r, DEV);
        send(8'h00, r);
        check("R8 ident byte 5", r, 8'hFF);
        deselect();
    endtask

    task automatic t_wake();
        logic [7:0] r;
        send(8'hAB, r);
        check("R9 dummy byte 2", r, 8'hFF);
        send(8'h00, r);
        check("R9 dummy byte 3", r, 8'hFF);
        send(8'h00, r);
        check("R9 dummy byte 4", r, 8'hFF);
        send(8'h00, r);
        check("R9 device byte 5", r, DEV);
        send(8'h00, r);
        check("R9 byte 6", r, 8'hFF);
        deselect();
    endtask

    task automatic t_mfrdev(input logic [7:0] sel);
        logic [7:0] r;
        send(8'h90, r);
        send(8'h00, r);
        send(8'h00, r);
        send(sel, r);
        check("R10 first id", r, (sel == 8'h00) ? MFR : DEV);
        send(8'h00, r);
        check("R10 second id", r, (sel == 8'h00) ? DEV : MFR);
        send(8'h00, r);
        check("R10 trailing byte", r, 8'hFF);
        deselect();
    endtask

    task automatic t_unknown();
        logic [7:0] r;
        send(8'h3A, r);
        check("R11 unknown opcode reply", r, 8'hFF);
        send(8'h05, r);
        check("R11 unknown stays 0xFF", r, 8'hFF);
        send(8'h9F, r);
        check("R11 unknown stays 0xFF later", r, 8'hFF);
        deselect();
        @(negedge clk);
        csn  = 1'b1;
        vld  = 1'b1;
        mosi = 8'h06;
        @(negedge clk);
        vld  = 1'b0;
        check("R11 miso idle while deselected", miso, 8'hFF);
        read_status("R11 strobe while deselected ignored", 8'h3C);
    endtask

    task automatic t_abort();
        logic [7:0] r;
        send(8'h9F, r);
        send(8'h00, r);
        check("R12 ident before abort", r, TYP);
        deselect();
        read_status("R12 new opcode after abort", 8'h3C);
    endtask

    task automatic t_lock();
        logic [7:0] r;
        send(8'h06, r);
        deselect();
        send(8'h01, r);
        send(8'h80, r);
        deselect();
        read_status("R5 lock bit written", 8'h80);
        send(8'h06, r);
        deselect();
        send(8'h01, r);
        send(8'h00, r);
        deselect();
        read_status("R7 locked write ignored, latch kept", 8'h82);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_wel();
        t_rdsr_repeat();
        t_wrsr();
        t_wrsr_rejects();
        t_ident();
        t_wake();
        t_mfrdev(8'h00);
        t_mfrdev(8'h01);
        t_unknown();
        t_abort();
        t_lock();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule